// File: doc/BRIEF.md
# Overlapped Block Sample Loader

This block steers incoming samples into the input buffer of a block transform engine. It sits between a sample source, which presents one sample per strobe cycle, and a buffer RAM that the block addresses. On each qualified sample it raises a write enable together with a circular buffer address. It tells the transform engine through a one-cycle pulse each time a complete block, which may overlap the previous block, sits in the buffer. Successive blocks may overlap by none, half or three quarters of their length. The incoming strobe is thinned by one, two or four to match the overlap, so the input and output sides can run from one shared strobe source.

There are two ways of working. In streaming operation, loading runs alongside the transform and a block-ready pulse is raised after every hop of new samples. In stored operation, and always for the largest block size, loading and transforming alternate. The loader fills one nominal block and then drops the load flag. When overlap is selected it keeps loading one hop of extra samples, so that two overlapped transforms can run from the stored data. It then stops and waits for the transform engine to go busy and come free again before it starts the next fill.

Configuration is latched by a one-cycle load strobe. Combinations that cannot be served raise a configuration error, and the loader stays quiet until a valid setting arrives.

Top module: `ovl_loader`

## Requirements
- R1: After reset, wr_en, block_ready, load_flag, cfg_err and wr_addr are all 0. No write happens on any strobe until a valid configuration has been latched.
- R2: The overlap code maps 0 to 0%, 1 to 50% and 2 to 75%. Accepted strobes are divided by 1, 2 or 4 to match. A write happens on the 1st, 2nd or 4th accepted strobe of each group, counted from the cycle after cfg_load.
- R3: A divided strobe that arrives while din_en is low produces no write, and the address does not advance. It still uses up its place in the divider.
- R4: The k-th write after cfg_load (k = 0, 1, ...) carries address k mod 2^(MAX_LOG2+1). The pointer is not reset between fills.
- R5: load_flag rises in the cycle after a valid cfg_load and after each refill start. It falls in the same cycle that the N-th write of the fill appears on wr_en, where N = 2^size.
- R6: In streaming operation (cfg_store = 0 and size below MAX_LOG2), block_ready pulses for one cycle with the N-th write and then with every hop-th write after it. The hop is N, N/2 or N/4 for overlap codes 0, 1 and 2. xform_busy has no effect in this operation.
- R7: In stored operation, a fill writes N + hop samples when overlap is nonzero and N samples when it is zero. block_ready pulses at write N and at write N + hop. Strobes after the fill is complete are ignored.
- R8: After a sequential fill completes, a rising xform_busy followed by a falling xform_busy starts a new fill. Its first write lands in the cycle after busy is seen low at the earliest.
- R9: In sequential operation, a strobe sampled while xform_busy is high is neither counted by the divider nor written.
- R10: With size equal to MAX_LOG2, operation is sequential even when cfg_store is 0, and a fill writes exactly N samples.
- R11: cfg_err is set on cfg_load in any of these cases: the size is below MIN_LOG2 or above MAX_LOG2, the overlap code is 3, or stored operation with nonzero overlap is requested at size MAX_LOG2. While cfg_err is set, nothing is written and load_flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Latch configuration, restart divider, pointer and fill |
| cfg_size_log2 | input | SIZE_W | Block length as log2 of the point count |
| cfg_overlap | input | 2 | Overlap code: 0 none, 1 half, 2 three quarters |
| cfg_store | input | 1 | 1 selects stored (sequential) operation |
| din_stb | input | 1 | Sample strobe, one sample per high cycle |
| din_en | input | 1 | Qualifies divided strobes for writing |
| xform_busy | input | 1 | Transform engine in progress |
| wr_addr | output | MAX_LOG2+1 | Buffer write address |
| wr_en | output | 1 | Buffer write enable |
| load_flag | output | 1 | High while the nominal block is still being loaded |
| block_ready | output | 1 | One-cycle pulse when a full block is buffered |
| cfg_err | output | 1 | Latched configuration error |

## Verification
The bench builds the loader with MAX_LOG2 = 6 and MIN_LOG2 = 4, so the only legal sizes are 16, 32 and 64 points and the address wraps at 128. With sizes this small, every overlap code in both operations, as well as the largest-size sequential case, can be swept across several complete fills and refills, and the address wrap is crossed many times. Each cycle is compared against an arithmetic model of strobe division, hop counting and busy handshakes. Every illegal configuration class is also applied.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    typedef logic [15:0] len_t;

    typedef enum logic [1:0] {
        OVL_NONE    = 2'd0,
        OVL_HALF    = 2'd1,
        OVL_QUARTER = 2'd2,
        OVL_BAD     = 2'd3
    } ovl_e;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_LOAD,
        FS_FULL,
        FS_BUSY
    } fill_st_e;

    typedef struct packed {
        logic [3:0] size_log2;
        ovl_e       ovl;
        logic       store;
    } cfg_t;

    function automatic len_t blk_len(input logic [3:0] lg);
        return len_t'(1) << lg;
    endfunction

    function automatic len_t hop_len(input logic [3:0] lg, input ovl_e o);
        case (o)
            OVL_HALF:    return blk_len(lg) >> 1;
            OVL_QUARTER: return blk_len(lg) >> 2;
            default:     return blk_len(lg);
        endcase
    endfunction

    // divider terminal count (ratio - 1)
    function automatic logic [1:0] div_last(input ovl_e o);
        case (o)
            OVL_HALF:    return 2'd1;
            OVL_QUARTER: return 2'd3;
            default:     return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ovl_strobe_div.sv
module ovl_strobe_div (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic [1:0] last,
    input  logic       stb,
    output logic       tick
);
    logic [1:0] cnt_q;

    assign tick = stb && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (stb) begin
            if (cnt_q == last) cnt_q <= '0;
            else               cnt_q <= cnt_q + 2'd1;
        end
    end

    // R2
    // two ticks in a row only when no division is selected
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && last != 2'd0 && !restart) |=> !tick)
        else $error("divided strobe too dense");

endmodule

// File: rtl/ovl_wr_ptr.sv
module ovl_wr_ptr #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          adv,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ptr_q  <= '0;
            addr_q <= '0;
        end else if (adv) begin
            addr_q <= ptr_q;
            ptr_q  <= ptr_q + 1'b1;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/ovl_fill_ctrl.sv
module ovl_fill_ctrl
    import ovl_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          err_in,
    input  logic          seq,
    input  logic [CW-1:0] blk_n,
    input  logic [CW-1:0] hop_n,
    input  logic [CW-1:0] tgt_n,
    input  logic          wr_evt,
    input  logic          busy,
    output logic          can_load,
    output logic          load_flag,
    output logic          block_ready
);
    fill_st_e      st_q;
    logic [CW-1:0] gap_q;
    logic [CW-1:0] left_q;
    logic          lf_q;
    logic          rdy_q;

    assign can_load    = (st_q == FS_LOAD) && !(seq && busy);
    assign load_flag   = lf_q;
    assign block_ready = rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= FS_IDLE;
            gap_q  <= '0;
            left_q <= '0;
            lf_q   <= 1'b0;
            rdy_q  <= 1'b0;
        end else if (restart) begin
            st_q   <= err_in ? FS_IDLE : FS_LOAD;
            gap_q  <= blk_n;
            left_q <= tgt_n;
            lf_q   <= !err_in;
            rdy_q  <= 1'b0;
        end else begin
            rdy_q <= 1'b0;
            case (st_q)
                FS_LOAD: begin
                    if (wr_evt) begin
                        if (gap_q == CW'(1)) begin
                            rdy_q <= 1'b1;
                            lf_q  <= 1'b0;
                            gap_q <= hop_n;
                        end else begin
                            gap_q <= gap_q - 1'b1;
                        end
                        if (seq) begin
                            left_q <= left_q - 1'b1;
                            if (left_q == CW'(1)) st_q <= FS_FULL;
                        end
                    end
                end
                FS_FULL: if (busy)  st_q <= FS_BUSY;
                FS_BUSY: if (!busy) begin
                    st_q   <= FS_LOAD;
                    gap_q  <= blk_n;
                    left_q <= tgt_n;
                    lf_q   <= 1'b1;
                end
                default: st_q <= FS_IDLE;
            endcase
        end
    end

    // R6
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rdy_q |=> !rdy_q)
        else $error("block ready wider than one cycle");

    // R5
    flag_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(lf_q) && !$past(restart)) |-> rdy_q)
        else $error("load flag fell without a completed block");

endmodule

// File: rtl/ovl_loader.sv
module ovl_loader
    import ovl_pkg::*;
#(
    parameter int MAX_LOG2 = 10,
    parameter int MIN_LOG2 = 4,
    parameter int SIZE_W   = 4,
    localparam int AW      = MAX_LOG2 + 1,
    localparam int CW      = MAX_LOG2 + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [SIZE_W-1:0] cfg_size_log2,
    input  logic [1:0]        cfg_overlap,
    input  logic              cfg_store,
    input  logic              din_stb,
    input  logic              din_en,
    input  logic              xform_busy,
    output logic [AW-1:0]     wr_addr,
    output logic              wr_en,
    output logic              load_flag,
    output logic              block_ready,
    output logic              cfg_err
);
    cfg_t cfg_q;
    cfg_t cfg_in;
    cfg_t cfg_eff;
    logic err_q;
    logic err_in;
    logic seq_eff;
    logic [CW-1:0] blk_n, hop_n, tgt_n;
    logic can_load, stb_acc, tick, wr_evt;
    logic wr_en_q;

    assign cfg_in.size_log2 = 4'(cfg_size_log2);
    assign cfg_in.ovl       = ovl_e'(cfg_overlap);
    assign cfg_in.store     = cfg_store;
    assign cfg_eff          = cfg_load ? cfg_in : cfg_q;

    // configuration legality
    always_comb begin
        err_in = 1'b0;
        if (int'(cfg_size_log2) < MIN_LOG2 || int'(cfg_size_log2) > MAX_LOG2)
            err_in = 1'b1;
        if (cfg_in.ovl == OVL_BAD)
            err_in = 1'b1;
        if (cfg_store && int'(cfg_size_log2) == MAX_LOG2 && cfg_in.ovl != OVL_NONE)
            err_in = 1'b1;
    end

    assign seq_eff = cfg_eff.store || (int'(cfg_eff.size_log2) == MAX_LOG2);
    assign blk_n   = CW'(blk_len(cfg_eff.size_log2));
    assign hop_n   = CW'(hop_len(cfg_eff.size_log2, cfg_eff.ovl));
    assign tgt_n   = (cfg_eff.store && cfg_eff.ovl != OVL_NONE) ? blk_n + hop_n : blk_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            err_q <= 1'b0;
        end else if (cfg_load) begin
            cfg_q <= cfg_in;
            err_q <= err_in;
        end
    end

    assign stb_acc = din_stb && can_load && !cfg_load;
    assign wr_evt  = tick && din_en;

    ovl_strobe_div u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (cfg_load),
        .last    (div_last(cfg_eff.ovl)),
        .stb     (stb_acc),
        .tick    (tick)
    );

    ovl_wr_ptr #(.AW(AW)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .restart (cfg_load),
        .adv     (wr_evt),
        .addr    (wr_addr)
    );

    ovl_fill_ctrl #(.CW(CW)) u_fill (
        .clk         (clk),
        .rst         (rst),
        .restart     (cfg_load),
        .err_in      (err_in),
        .seq         (seq_eff),
        .blk_n       (blk_n),
        .hop_n       (hop_n),
        .tgt_n       (tgt_n),
        .wr_evt      (wr_evt),
        .busy        (xform_busy),
        .can_load    (can_load),
        .load_flag   (load_flag),
        .block_ready (block_ready)
    );

    always_ff @(posedge clk) begin
        if (rst || cfg_load) wr_en_q <= 1'b0;
        else                 wr_en_q <= wr_evt;
    end

    assign wr_en   = wr_en_q;
    assign cfg_err = err_q;

    // R11
    err_silent_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!wr_en && !load_flag))
        else $error("activity under configuration error");

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xform_busy && (cfg_q.store || int'(cfg_q.size_log2) == MAX_LOG2) && !cfg_load) |=> !wr_en)
        else $error("write while transform busy in sequential operation");

endmodule

// File: tb/ovl_loader_test.sv
module ovl_loader_test;
    localparam int MAXL = 6;
    localparam int MINL = 4;
    localparam int AWT  = MAXL + 1;

    logic clk = 1'b0;
    logic rst;
    logic cfg_load, cfg_store, din_stb, din_en, xform_busy;
    logic [3:0] cfg_size_log2;
    logic [1:0] cfg_overlap;
    logic [AWT-1:0] wr_addr;
    logic wr_en, load_flag, block_ready, cfg_err;

    always #5 clk = ~clk;

    ovl_loader #(.MAX_LOG2(MAXL), .MIN_LOG2(MINL), .SIZE_W(4)) uut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_size_log2(cfg_size_log2),
        .cfg_overlap(cfg_overlap), .cfg_store(cfg_store), .din_stb(din_stb),
        .din_en(din_en), .xform_busy(xform_busy), .wr_addr(wr_addr), .wr_en(wr_en),
        .load_flag(load_flag), .block_ready(block_ready), .cfg_err(cfg_err)
    );

    int total_chk = 0;
    int bad_chk   = 0;
    bit finished  = 0;

    // bench model state
    bit cfgd, m_err, m_seq;
    int m_n, m_ratio, m_hop, m_tgt;
    int m_sc, m_total, m_wcnt, m_phase;
    bit e_lf, e_wr, e_rdy;
    int e_addr;
    string tag;

    task automatic chk(input string req, input string what, input int got, input int exp);
        total_chk++;
        if (got != exp) begin
            bad_chk++;
            $display("FAIL %s %s got=%0d exp=%0d t=%0t", req, what, got, exp, $time);
        end
    endtask

    task automatic check_all();
        chk(tag, "wr_en", int'(wr_en), int'(e_wr));
        chk(tag, "wr_addr", int'(wr_addr), e_addr);
        chk(tag, "block_ready", int'(block_ready), int'(e_rdy));
        chk(tag, "load_flag R5", int'(load_flag), int'(e_lf));
        chk(tag, "cfg_err R11", int'(cfg_err), int'(m_err));
    endtask

    task automatic apply_cfg(input int sz, input int ov, input bit st);
        @(negedge clk);
        cfg_load = 1; cfg_size_log2 = 4'(sz); cfg_overlap = 2'(ov); cfg_store = st;
        din_stb = 0; xform_busy = 0;
        m_err = (sz < MINL) || (sz > MAXL) || (ov == 3) || (st && sz == MAXL && ov != 0);
        m_n     = 1 << sz;
        m_ratio = (ov == 1) ? 2 : (ov == 2) ? 4 : 1;
        m_hop   = m_n / m_ratio;
        m_seq   = st || (sz == MAXL);
        m_tgt   = (st && ov != 0) ? m_n + m_hop : m_n;
        m_sc = 0; m_total = 0; m_wcnt = 0; m_phase = 0;
        e_lf = !m_err; e_wr = 0; e_rdy = 0; e_addr = 0;
        cfgd = 1;
        @(posedge clk); #1;
        check_all();
        @(negedge clk);
        cfg_load = 0;
    endtask

    task automatic cyc(input bit s, input bit en, input bit busy);
        int old_phase;
        bit acc;
        @(negedge clk);
        din_stb = s; din_en = en; xform_busy = busy;
        old_phase = m_phase;
        e_wr = 0; e_rdy = 0;
        acc = cfgd && !m_err && s && old_phase == 0 && !(m_seq && busy);
        if (acc) begin
            m_sc++;
            if ((m_sc % m_ratio) == 0 && en) begin
                e_wr = 1;
                e_addr = m_total % (1 << AWT);
                m_total++;
                m_wcnt++;
                if (m_wcnt == m_n) begin
                    e_rdy = 1; e_lf = 0;
                end else if (m_wcnt > m_n && ((m_wcnt - m_n) % m_hop) == 0) begin
                    e_rdy = 1;
                end
                if (m_seq && m_wcnt == m_tgt) m_phase = 1;
            end
        end
        if (old_phase == 1 && busy) m_phase = 2;
        else if (old_phase == 2 && !busy) begin
            m_phase = 0; m_wcnt = 0; e_lf = 1;
        end
        @(posedge clk); #1;
        check_all();
    endtask

    task automatic run_pattern(input int ncyc, input int seed);
        for (int c = 0; c < ncyc; c++) begin
            cyc(((c * 5 + seed) % 7) != 3, (c % 5) != 2, ((c + seed) % 11) < 3);
        end
    endtask

    initial begin
        rst = 1; cfg_load = 0; cfg_size_log2 = 0; cfg_overlap = 0; cfg_store = 0;
        din_stb = 0; din_en = 0; xform_busy = 0;
        cfgd = 0; m_err = 0; e_lf = 0; e_wr = 0; e_rdy = 0; e_addr = 0;
        m_ratio = 1; m_hop = 1; m_n = 1; m_tgt = 1; m_seq = 0;
        repeat (3) @(posedge clk);
        #1;
        tag = "R1";
        check_all();
        @(negedge clk);
        rst = 0;
        // R1: strobes before any configuration do nothing
        for (int c = 0; c < 10; c++) cyc(1, 1, 0);

        // R2 R4 R5 R6: plain streaming, full enable, busy ignored
        tag = "R2 R4 R6";
        apply_cfg(4, 0, 0);
        for (int c = 0; c < 300; c++) cyc(1, 1, (c % 4) == 0);

        // R3 R6: streaming sweep with gaps in din_en and busy toggling
        tag = "R3 R6";
        for (int sz = 4; sz <= 5; sz++)
            for (int ov = 0; ov <= 2; ov++) begin
                apply_cfg(sz, ov, 0);
                run_pattern(500, sz + ov);
            end

        // R7 R8 R9: stored operation sweep with refills
        tag = "R7 R8 R9";
        for (int sz = 4; sz <= 5; sz++)
            for (int ov = 0; ov <= 2; ov++) begin
                apply_cfg(sz, ov, 1);
                run_pattern(600, 2 * sz + ov);
            end

        // R10: largest size is sequential in either operation
        tag = "R10";
        for (int ov = 0; ov <= 2; ov++) begin
            apply_cfg(MAXL, ov, 0);
            run_pattern(700, ov);
        end
        apply_cfg(MAXL, 0, 1);
        run_pattern(700, 3);

        // R11: illegal configurations stay silent
        tag = "R11";
        apply_cfg(MAXL, 1, 1);
        run_pattern(40, 1);
        apply_cfg(3, 0, 0);
        run_pattern(40, 2);
        apply_cfg(4, 3, 0);
        run_pattern(40, 3);
        apply_cfg(7, 0, 1);
        run_pattern(40, 4);
        // recovery after an error
        tag = "R11 R2";
        apply_cfg(5, 1, 0);
        run_pattern(200, 5);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            total_chk++;
            bad_chk++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
            $finish;
        end
    end

endmodule